// File: doc/BRIEF.md
# Audio Controller Global Reset and Interrupt Status

This block holds the top-level control word, the global interrupt status word and a one-byte semaphore for an audio controller that has three DMA channels: capture (channel 0), playback (channel 1) and microphone (channel 2). It owns the controller-wide reset sequence. Bit 1 of the control word is an active-low cold-reset release, and the block powers up with that bit at 0. While the bit is 0, no register write other than a write to the control word takes effect. Bit 2 asks for a warm reset. That bit clears itself, and the block does not act on it while a stream is running.

Each channel sends this block a level that says whether its own interrupt evaluation is asserted. The block copies those levels into the status word and drives a single registered interrupt line. Software reaches the block over a simple register bus with byte and dword accesses. The block gives each channel a one-cycle reset pulse and a one-cycle halt pulse. It also passes a write strobe on to the channel registers, and it blocks that strobe while the controller is in cold reset.

Top module: `aud_glob_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x2C), the status word (0x30) and the semaphore (0x34) all read 0. `irq_o`, `chan_rst_o` and `chan_halt_o` are 0, and `cold_o` is 1.
- R2: While control bit 1 is 0, writes to the semaphore are discarded and `chan_wr_o` stays 0. A dword write to the control word is still accepted.
- R3: A dword write to the control word with bit 1 = 0 stores the written value with bit 2 forced to 0. It also pulses all `chan_rst_o` bits for exactly one cycle and clears the semaphore, so writing 0x74 or 0x70 reads back as 0x70.
- R4: A dword write to the control word with bit 1 = 1 and bit 2 = 0 is stored as written (0x72 reads back as 0x72). `cold_o` then goes to 0, and `chan_wr_o` follows `bus_wr_i` for addresses outside 0x2C, 0x30 and 0x34.
- R5: A warm reset request (bit 1 = 1, bit 2 = 1) made while `run_i[0]` (capture) and `run_i[1]` (playback) are both 0 stores the value with bit 2 cleared (0x76 reads 0x72). It pulses all `chan_halt_o` bits for one cycle, does not pulse `chan_rst_o`, and leaves the semaphore unchanged.
- R6: A warm reset request made while capture or playback is running is stored unchanged (0x76 reads 0x76) and does not pulse `chan_halt_o`. A running microphone channel (`run_i[2]`) does not block a warm reset.
- R7: Status bit i (bits [2:0] at 0x30) equals `chan_irq_i[i]` delayed by one clock. Writes to 0x30 have no effect.
- R8: `irq_o` is the OR of the three status bits delayed by one more clock.
- R9: Once cold reset is released, a write to 0x34 stores `bus_wdata_i[7:0]`, which reads back in bits [7:0].
- R10: A byte write (`bus_byte_i` = 1) to the control word is ignored. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_byte_i | input | 1 | 1 = byte access, 0 = dword access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| chan_irq_i | input | 3 | Per-channel interrupt evaluation level |
| run_i | input | 3 | Per-channel stream running flag |
| chan_rst_o | output | 3 | One-cycle channel reset pulse |
| chan_halt_o | output | 3 | One-cycle channel stop pulse |
| chan_wr_o | output | 1 | Write strobe passed on to channel registers |
| cold_o | output | 1 | High while held in cold reset |
| irq_o | output | 1 | Registered global interrupt |

## Verification
The bench targets the corner cases of the reset sequence:
- **Semaphore write while still in cold reset.** A design with weak gating would keep the written byte.
- **Byte write to the control word.** A design that accepted it could fall back into cold reset by accident.
- **Warm reset with each running flag set on its own.** A design with the wrong mask would either halt a live stream or refuse to halt when only the microphone is running.
- **Combined cold and warm request.** A design with the wrong priority would keep bit 2 set, or would halt instead of reset.

Random interrupt levels interleaved with random semaphore writes show whether each status bit and the interrupt output have the right delay, and whether a status bit is wired to the wrong channel.

// File: rtl/aud_glob_pkg.sv
package aud_glob_pkg;
    localparam int unsigned CTL_COLD_BIT = 1;
    localparam int unsigned CTL_WARM_BIT = 2;
    localparam int unsigned RUN_CAPTURE  = 0;
    localparam int unsigned RUN_PLAYBACK = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_STS  = 2'd2,
        SEL_SEMA = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/aud_glob_ctl_reg.sv
module aud_glob_ctl_reg #(
    parameter int unsigned DW = 32,
    parameter int unsigned NCH = 3,
    parameter logic [NCH-1:0] RUN_MASK = 3'b011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [NCH-1:0] run_i,
    output logic [DW-1:0]  ctl_o,
    output logic           open_o,
    output logic           sema_clr_o,
    output logic [NCH-1:0] rst_o,
    output logic [NCH-1:0] halt_o
);
    import aud_glob_pkg::*;

    localparam logic [DW-1:0] WARM_M = {{(DW-1){1'b0}}, 1'b1} << CTL_WARM_BIT;

    typedef struct packed {
        logic [DW-1:0]  ctl;
        logic [NCH-1:0] rst;
        logic [NCH-1:0] halt;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       busy;

    assign busy = |(run_i & RUN_MASK);

    always_comb begin
        st_d      = st_q;
        st_d.rst  = '0;
        st_d.halt = '0;
        if (wr_i) begin
            if (!wdata_i[CTL_COLD_BIT]) begin
                st_d.ctl = wdata_i & ~WARM_M;
                st_d.rst = '1;
            end else if (wdata_i[CTL_WARM_BIT] && !busy) begin
                st_d.ctl  = wdata_i & ~WARM_M;
                st_d.halt = '1;
            end else begin
                st_d.ctl = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o      = st_q.ctl;
    assign open_o     = st_q.ctl[CTL_COLD_BIT];
    assign sema_clr_o = wr_i && !wdata_i[CTL_COLD_BIT];
    assign rst_o      = st_q.rst;
    assign halt_o     = st_q.halt;

    // R3
    rst_in_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.rst) |-> !st_q.ctl[CTL_COLD_BIT]);
    // R5
    warm_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.halt) |-> !st_q.ctl[CTL_WARM_BIT]);
    // R6
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.halt) |-> !(|($past(run_i) & RUN_MASK)));
    // R5
    rst_halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|st_q.rst) && (|st_q.halt)));
endmodule

// File: rtl/aud_glob_sema.sv
module aud_glob_sema #(
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          clr_i,
    input  logic [SW-1:0] wdata_i,
    output logic [SW-1:0] sema_o
);
    logic [SW-1:0] sema_d, sema_q;

    always_comb begin
        sema_d = sema_q;
        if (clr_i)     sema_d = '0;
        else if (wr_i) sema_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sema_q <= '0;
        else        sema_q <= sema_d;
    end

    assign sema_o = sema_q;

    // R3
    sema_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sema_q == '0));
endmodule

// File: rtl/aud_glob_irq_agg.sv
module aud_glob_irq_agg #(
    parameter int unsigned NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_i,
    output logic [NCH-1:0] sts_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [NCH-1:0] sts;
        logic           irq;
    } agg_state_t;

    agg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = irq_i;
        st_d.irq = |st_q.sts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign irq_o = st_q.irq;

    // R7
    sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.sts) |-> $past(|irq_i));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(|st_q.sts));
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.sts) == '0) |-> !st_q.irq);
endmodule

// File: rtl/aud_glob_ctrl.sv
module aud_glob_ctrl #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 8,
    parameter int unsigned NCH = 3,
    parameter int unsigned SW = 8,
    parameter logic [AW-1:0] CTL_OFS = 8'h2C,
    parameter logic [AW-1:0] STS_OFS = 8'h30,
    parameter logic [AW-1:0] SEMA_OFS = 8'h34,
    parameter logic [NCH-1:0] RUN_MASK = 3'b011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr_i,
    input  logic           bus_wr_i,
    input  logic           bus_byte_i,
    input  logic [DW-1:0]  bus_wdata_i,
    output logic [DW-1:0]  bus_rdata_o,
    input  logic [NCH-1:0] chan_irq_i,
    input  logic [NCH-1:0] run_i,
    output logic [NCH-1:0] chan_rst_o,
    output logic [NCH-1:0] chan_halt_o,
    output logic           chan_wr_o,
    output logic           cold_o,
    output logic           irq_o
);
    import aud_glob_pkg::*;

    reg_sel_e      sel;
    logic          open;
    logic          ctl_wr, sema_wr, sema_clr;
    logic [DW-1:0] ctl;
    logic [SW-1:0] sema;
    logic [NCH-1:0] sts;

    always_comb begin
        if (bus_addr_i == CTL_OFS)       sel = SEL_CTL;
        else if (bus_addr_i == STS_OFS)  sel = SEL_STS;
        else if (bus_addr_i == SEMA_OFS) sel = SEL_SEMA;
        else                             sel = SEL_NONE;
    end

    assign ctl_wr    = bus_wr_i && !bus_byte_i && (sel == SEL_CTL);
    assign sema_wr   = bus_wr_i && open && (sel == SEL_SEMA);
    assign chan_wr_o = bus_wr_i && open && (sel == SEL_NONE);
    assign cold_o    = !open;

    aud_glob_ctl_reg #(.DW(DW), .NCH(NCH), .RUN_MASK(RUN_MASK)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .wdata_i(bus_wdata_i),
        .run_i(run_i), .ctl_o(ctl), .open_o(open), .sema_clr_o(sema_clr),
        .rst_o(chan_rst_o), .halt_o(chan_halt_o)
    );

    aud_glob_sema #(.SW(SW)) u_sema (
        .clk(clk), .rst_n(rst_n), .wr_i(sema_wr), .clr_i(sema_clr),
        .wdata_i(bus_wdata_i[SW-1:0]), .sema_o(sema)
    );

    aud_glob_irq_agg #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_i(chan_irq_i), .sts_o(sts), .irq_o(irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            SEL_CTL:  bus_rdata_o = ctl;
            SEL_STS:  bus_rdata_o[NCH-1:0] = sts;
            SEL_SEMA: bus_rdata_o[SW-1:0] = sema;
            default:  bus_rdata_o = '0;
        endcase
    end

    // R2
    cold_sema_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_o && bus_wr_i && sel == SEL_SEMA) |=> $stable(sema));
    // R2
    cold_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_o |-> !chan_wr_o);
    // R10
    byte_ctl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_byte_i && sel == SEL_CTL) |=> $stable(ctl));
endmodule

// File: tb/aud_glob_ctrl_bench.sv
`timescale 1ns/10ps
module aud_glob_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  chan_irq = '0;
    logic [2:0]  run = '0;
    logic [2:0]  chan_rst, chan_halt;
    logic        chan_wr, cold, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    aud_glob_ctrl u_aud_glob_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_byte_i(bus_byte), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .chan_irq_i(chan_irq), .run_i(run), .chan_rst_o(chan_rst),
        .chan_halt_o(chan_halt), .chan_wr_o(chan_wr), .cold_o(cold), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic byt);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_byte = byt; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    function automatic logic [31:0] exp_ctl(input logic [31:0] v, input logic [2:0] r);
        if (!v[1]) return v & ~32'h4;
        if (v[2] && (r[1:0] == 2'b00)) return v & ~32'h4;
        return v;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  prev_irq, prev2_irq;
        logic [7:0]  exp_sema;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h2C, d); chk("R1 ctl", d, 0);
        rd(8'h30, d); chk("R1 sts", d, 0);
        rd(8'h34, d); chk("R1 sema", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 cold", {31'b0, cold}, 1);
        chk("R1 pulses", {26'b0, chan_rst, chan_halt}, 0);

        // R2 writes gated during cold reset
        wr(8'h34, 32'hA5, 1'b1);
        rd(8'h34, d); chk("R2 sema gated", d, 0);
        bus_addr = 8'h10; bus_wr = 1'b1; #0.1;
        chk("R2 chan_wr gated", {31'b0, chan_wr}, 0);
        bus_wr = 1'b0;

        // R4 release
        wr(8'h2C, 32'h72, 1'b0);
        rd(8'h2C, d); chk("R4 ctl 0x72", d, exp_ctl(32'h72, run));
        chk("R4 cold low", {31'b0, cold}, 0);
        bus_addr = 8'h10; bus_wr = 1'b1; #0.1;
        chk("R4 chan_wr pass", {31'b0, chan_wr}, 1);
        bus_addr = 8'h34; #0.1;
        chk("R4 chan_wr own addr", {31'b0, chan_wr}, 0);
        bus_wr = 1'b0;

        // R9 semaphore
        wr(8'h34, 32'hFFFF_FF5A, 1'b1);
        rd(8'h34, d); chk("R9 sema", d, 32'h5A);

        // R10 byte write to control ignored, unmapped read
        wr(8'h2C, 32'h0, 1'b1);
        rd(8'h2C, d); chk("R10 byte ctl", d, 32'h72);
        chk("R10 no rst", {29'b0, chan_rst}, 0);
        rd(8'h3C, d); chk("R10 unmapped", d, 0);

        // R5 warm reset idle
        wr(8'h2C, 32'h76, 1'b0);
        rd(8'h2C, d); chk("R5 ctl", d, exp_ctl(32'h76, 3'b000));
        chk("R5 halt", {29'b0, chan_halt}, 3'b111);
        chk("R5 no rst", {29'b0, chan_rst}, 0);
        rd(8'h34, d); chk("R5 sema kept", d, 32'h5A);
        @(negedge clk);
        chk("R5 halt one cycle", {29'b0, chan_halt}, 0);

        // R6 warm blocked by playback, then capture
        run = 3'b010;
        wr(8'h2C, 32'h76, 1'b0);
        rd(8'h2C, d); chk("R6 playback", d, exp_ctl(32'h76, run));
        chk("R6 no halt pb", {29'b0, chan_halt}, 0);
        run = 3'b001;
        wr(8'h2C, 32'h76, 1'b0);
        rd(8'h2C, d); chk("R6 capture", d, 32'h76);
        chk("R6 no halt cap", {29'b0, chan_halt}, 0);
        run = 3'b100;
        wr(8'h2C, 32'h76, 1'b0);
        rd(8'h2C, d); chk("R6 mic only", d, 32'h72);
        chk("R6 mic halt", {29'b0, chan_halt}, 3'b111);
        run = 3'b000;

        // R3 cold reset write with warm bit set
        wr(8'h2C, 32'h74, 1'b0);
        rd(8'h2C, d); chk("R3 ctl", d, exp_ctl(32'h74, run));
        chk("R3 rst", {29'b0, chan_rst}, 3'b111);
        chk("R3 no halt", {29'b0, chan_halt}, 0);
        rd(8'h34, d); chk("R3 sema clr", d, 0);
        chk("R3 cold", {31'b0, cold}, 1);
        @(negedge clk);
        chk("R3 rst one cycle", {29'b0, chan_rst}, 0);
        wr(8'h2C, 32'h70, 1'b0);
        rd(8'h2C, d); chk("R3 ctl 0x70", d, 32'h70);

        // R7 status is read-only
        wr(8'h2C, 32'h02, 1'b0);
        wr(8'h30, 32'hFFFF_FFFF, 1'b0);
        rd(8'h30, d); chk("R7 sts ro", d, 0);

        // R7 R8 random interrupt levels with semaphore traffic
        prev_irq = '0; prev2_irq = '0; exp_sema = 8'h00;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            rd(8'h30, d); chk("R7 sts follow", d, {29'b0, prev_irq});
            chk("R8 irq", {31'b0, irq}, {31'b0, |prev2_irq});
            rd(8'h34, d); chk("R9 sema rand", d, {24'b0, exp_sema});
            prev2_irq = prev_irq;
            chan_irq = 3'($urandom);
            if (k % 7 == 3) chan_irq = 3'b000;
            prev_irq = chan_irq;
            bus_wr = 1'b0;
            if (($urandom % 4) == 0) begin
                bus_wdata = $urandom;
                bus_addr = 8'h34; bus_byte = 1'b1; bus_wr = 1'b1;
                exp_sema = bus_wdata[7:0];
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        done = 1;
        summary();
    end
endmodule